// File: doc/BRIEF.md
# Dual-Path Vectored Interrupt Controller

This controller gathers interrupt requests from a set of peripheral channels and keeps each one in a pending bit until the controller itself clears it. Requests can be levels or single-cycle pulses. A per-channel routing mask sends each channel to either the normal path or the fast path. A per-channel enable mask decides whether a pending channel may reach its path at all. Within each path, the lowest-numbered enabled pending channel wins.

For each path the controller raises an interrupt output. It also reports the winner in two places. The index register holds the channel number plus one, or zero when the path is idle. The vector register holds the handler address taken from an internal table of handler addresses. The table has one entry per channel and is written over the register bus.

There are three ways to clear a pending bit:
- read that path's vector register, which clears the channel it reported;
- write ones to the pending register;
- on the normal path only, acknowledge the direct vector port. This port hands the winning handler address to the CPU with a valid/acknowledge handshake.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A request that is high at a clock edge sets that channel's bit in the pending register (address 0x00, bit n = channel n). The bit stays set after the request drops. It also stays set while the request is still high, even if a clear is applied in the same cycle.
- R2: Writing the pending register clears each bit written as 1. Bits written as 0 keep their state.
- R3: The enable register (address 0x01, bit n = channel n, reset 0) stops a disabled channel from reaching either path. Its pending bit still latches, and the channel appears once it is enabled.
- R4: The routing register (address 0x02, bit n = channel n, reset 0) sends a channel to the fast path when its bit is 1 and to the normal path when its bit is 0.
- R5: Among the enabled pending channels of one path, the lowest-numbered channel is reported.
- R6: The normal index register (address 0x03) and the fast index register (address 0x04) read channel+1, or 0 when nothing is eligible on that path. `irq_o` and `fiq_o` are high exactly while the matching index is non-zero. Both follow the pending state one clock later.
- R7: Handler entries are written at address 0x20+n for channel n. The normal vector register (0x05) and the fast vector register (0x06) read the entry of the path's reported channel, or 0 when the path is idle.
- R8: Reading a vector register clears the pending bit of the channel it returned. A read while the path is idle clears nothing.
- R9: `vport_valid` rises with `vport_addr` set to the normal path's handler address. The address stays stable until `vport_ack` is sampled high. That acknowledge clears the reported pending bit and drops `vport_valid` for at least one cycle.
- R10: A channel routed to the fast path is never presented on the vector port.
- R11: After reset, all registers read 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NCH | Peripheral request lines, one per channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| irq_o | output | 1 | Normal-path interrupt |
| fiq_o | output | 1 | Fast-path interrupt |
| vport_valid | output | 1 | Direct vector port address valid |
| vport_addr | output | VW | Direct vector port handler address |
| vport_ack | input | 1 | CPU acknowledge of the vector port address |

## Verification
Requests are applied in several patterns, and each pattern separates a different fault:
- Single pulses with the enable mask off show that latching is independent of masking.
- A request held high through a clear shows that set takes precedence over clear.
- Three channels raised together and drained by vector reads expose a priority encoder that picks the wrong end, or a clear that hits the wrong bit.
- A masked channel read while the path is idle shows the idle read is harmless.
- Mixed fast and normal channels show that the two paths and the port stay separate.
- The port is held across several idle cycles and then acknowledged, which tests both address stability and the drop of `vport_valid` after acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam logic [BUS_AW-1:0] A_PEND = 6'h00;
  localparam logic [BUS_AW-1:0] A_ENA  = 6'h01;
  localparam logic [BUS_AW-1:0] A_FSEL = 6'h02;
  localparam logic [BUS_AW-1:0] A_NIDX = 6'h03;
  localparam logic [BUS_AW-1:0] A_FIDX = 6'h04;
  localparam logic [BUS_AW-1:0] A_NVEC = 6'h05;
  localparam logic [BUS_AW-1:0] A_FVEC = 6'h06;
  localparam int unsigned TBL_BIT = 5;
  localparam int unsigned P_NORM = 0;
  localparam int unsigned P_FAST = 1;
  localparam int unsigned NPATH  = 2;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_vtable.sv
module vic_vtable #(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vic_path.sv
module vic_path #(
  parameter int unsigned NCH  = 32,
  parameter int unsigned VW   = 32,
  parameter int unsigned IDXW = 8,
  parameter int unsigned CHW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  req_m,
  input  logic            tbl_we,
  input  logic [CHW-1:0]  tbl_waddr,
  input  logic [VW-1:0]   tbl_wdata,
  output logic [IDXW-1:0] idx_q,
  output logic            active_q,
  output logic [VW-1:0]   vec,
  output logic [CHW-1:0]  win_ch
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic           found;
  logic [CHW-1:0] wch;
  logic [VW-1:0]  tbl_q;

  vic_prio #(.N(NCH), .IW(CHW)) u_prio (
    .req(req_m), .found(found), .idx(wch)
  );

  vic_vtable #(.N(NCH), .DW(VW), .IW(CHW)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(wch), .rdata(tbl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else begin
      idx_q    <= found ? (IDXW'(wch) + IDXW'(1)) : '0;
      active_q <= found;
    end
  end

  assign vec    = active_q ? tbl_q : '0;
  assign win_ch = CHW'(idx_q - IDXW'(1));

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDXW'(NCH));

  // R6
  idle_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((idx_q == '0) == ($past(req_m) == '0)));

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_q != '0) |-> (((($past(req_m) >> win_ch) & ONE) == ONE) &&
                       (($past(req_m) & ((ONE << win_ch) - ONE)) == '0)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NCH  = 32,
  parameter int unsigned VW   = 32,
  parameter int unsigned IDXW = 8,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    irq_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              vport_valid,
  output logic [VW-1:0]     vport_addr,
  input  logic              vport_ack
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]  pend_q, ena_q, fsel_q, clr_v;
  logic [NCH-1:0]  req_p [NPATH];
  logic [IDXW-1:0] idx_p [NPATH];
  logic [VW-1:0]   vec_p [NPATH];
  logic [CHW-1:0]  wch_p [NPATH];
  logic [NPATH-1:0] act_p;

  logic rd, wr, tbl_we;
  logic           port_valid_q, hold_q;
  logic [VW-1:0]  port_addr_q;
  logic [CHW-1:0] port_ch_q;

  assign rd     = bus_sel && !bus_wr;
  assign wr     = bus_sel && bus_wr;
  assign tbl_we = wr && bus_addr[TBL_BIT];

  assign req_p[P_NORM] = pend_q & ena_q & ~fsel_q;
  assign req_p[P_FAST] = pend_q & ena_q & fsel_q;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    vic_path #(.NCH(NCH), .VW(VW), .IDXW(IDXW), .CHW(CHW)) u_path (
      .clk(clk), .rst(rst), .req_m(req_p[p]),
      .tbl_we(tbl_we), .tbl_waddr(bus_addr[CHW-1:0]),
      .tbl_wdata(VW'(bus_wdata)),
      .idx_q(idx_p[p]), .active_q(act_p[p]),
      .vec(vec_p[p]), .win_ch(wch_p[p])
    );
  end

  always_comb begin
    clr_v = '0;
    if (wr && bus_addr == A_PEND) clr_v = bus_wdata[NCH-1:0];
    if (rd && bus_addr == A_NVEC && act_p[P_NORM]) clr_v[wch_p[P_NORM]] = 1'b1;
    if (rd && bus_addr == A_FVEC && act_p[P_FAST]) clr_v[wch_p[P_FAST]] = 1'b1;
    if (port_valid_q && vport_ack) clr_v[port_ch_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      ena_q     <= '0;
      fsel_q    <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | irq_src;
      if (wr && bus_addr == A_ENA)  ena_q  <= bus_wdata[NCH-1:0];
      if (wr && bus_addr == A_FSEL) fsel_q <= bus_wdata[NCH-1:0];
      if (rd) begin
        case (bus_addr)
          A_PEND:  bus_rdata <= DW'(pend_q);
          A_ENA:   bus_rdata <= DW'(ena_q);
          A_FSEL:  bus_rdata <= DW'(fsel_q);
          A_NIDX:  bus_rdata <= DW'(idx_p[P_NORM]);
          A_FIDX:  bus_rdata <= DW'(idx_p[P_FAST]);
          A_NVEC:  bus_rdata <= DW'(vec_p[P_NORM]);
          A_FVEC:  bus_rdata <= DW'(vec_p[P_FAST]);
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_valid_q <= 1'b0;
      port_addr_q  <= '0;
      port_ch_q    <= '0;
      hold_q       <= 1'b0;
    end else begin
      hold_q <= 1'b0;
      if (port_valid_q && vport_ack) begin
        port_valid_q <= 1'b0;
        hold_q       <= 1'b1;
      end else if (!port_valid_q && !hold_q && act_p[P_NORM]) begin
        port_valid_q <= 1'b1;
        port_addr_q  <= vec_p[P_NORM];
        port_ch_q    <= wch_p[P_NORM];
      end
    end
  end

  assign irq_o       = act_p[P_NORM];
  assign fiq_o       = act_p[P_FAST];
  assign vport_valid = port_valid_q;
  assign vport_addr  = port_addr_q;

  // R1
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_v)) & ~pend_q) == '0));

  // R9
  port_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_q && !vport_ack) |=> (port_valid_q && $stable(port_addr_q)));

  // R9
  port_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (port_valid_q && vport_ack) |=> !port_valid_q);

  // R9
  port_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(port_valid_q) |-> $past(act_p[P_NORM]));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic [NCH-1:0] irq_src;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o, vport_valid, vport_ack;
  logic [31:0] vport_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o),
    .vport_valid(vport_valid), .vport_addr(vport_addr), .vport_ack(vport_ack)
  );

  function automatic logic [31:0] vexp(int ch);
    return 32'hA000_0005 | (32'(ch) << 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] m);
    irq_src = m;
    @(negedge clk);
    irq_src = '0;
  endtask

  task automatic ack_port();
    vport_ack = 1'b1;
    @(negedge clk);
    vport_ack = 1'b0;
  endtask

  task automatic tc_reset();
    logic [31:0] d;
    bus_read(6'h00, d); check("R11 pend", d, 0);
    bus_read(6'h01, d); check("R11 ena", d, 0);
    bus_read(6'h03, d); check("R11 nidx", d, 0);
    check("R11 outputs", {29'd0, irq_o, fiq_o, vport_valid}, 0);
  endtask

  task automatic tc_latch();
    logic [31:0] d;
    pulse(32'h0000_0020);
    idle(3);
    bus_read(6'h00, d); check("R1 pulse latched", d, 32'h0000_0020);
    bus_read(6'h03, d); check("R3 masked nidx", d, 0);
    check("R3 masked irq_o", {31'd0, irq_o}, 0);
  endtask

  task automatic tc_w1c();
    logic [31:0] d;
    pulse(32'h0000_0200);
    bus_write(6'h00, 32'h0000_0020);
    idle(2);
    bus_read(6'h00, d); check("R2 w1c one bit", d, 32'h0000_0200);
    bus_write(6'h00, 32'h0);
    idle(2);
    bus_read(6'h00, d); check("R2 zero write no effect", d, 32'h0000_0200);
    irq_src = 32'h0200_0000;
    @(negedge clk);
    bus_write(6'h00, 32'h0200_0000);
    idle(1);
    bus_read(6'h00, d); check("R1 held request survives clear", d, 32'h0200_0200);
    irq_src = '0;
    bus_write(6'h00, 32'hFFFF_FFFF);
    idle(2);
    bus_read(6'h00, d); check("R2 clear all", d, 0);
  endtask

  task automatic tc_prio();
    logic [31:0] d;
    bus_write(6'h01, 32'hFFFF_FFFF);
    pulse(32'h0010_0088);
    idle(3);
    check("R6 irq_o high", {31'd0, irq_o}, 1);
    bus_read(6'h03, d); check("R5 R6 nidx lowest", d, 4);
    bus_read(6'h05, d); check("R7 nvec ch3", d, vexp(3));
    idle(3);
    bus_read(6'h03, d); check("R8 nidx after read clear", d, 8);
    bus_read(6'h05, d); check("R7 nvec ch7", d, vexp(7));
    idle(3);
    bus_read(6'h03, d); check("R5 nidx ch20", d, 21);
    bus_read(6'h05, d); check("R7 nvec ch20", d, vexp(20));
    idle(3);
    bus_read(6'h03, d); check("R6 nidx idle", d, 0);
    check("R6 irq_o low", {31'd0, irq_o}, 0);
    bus_read(6'h00, d); check("R8 pend drained", d, 0);
    check("R9 port holds first", vport_addr, vexp(3));
    ack_port();
    idle(3);
    check("R9 port idle", {31'd0, vport_valid}, 0);
  endtask

  task automatic tc_masked_read();
    logic [31:0] d;
    bus_write(6'h01, ~32'h0000_1000);
    pulse(32'h0000_1000);
    idle(3);
    bus_read(6'h05, d); check("R7 idle nvec zero", d, 0);
    idle(1);
    bus_read(6'h00, d); check("R8 idle read clears nothing", d, 32'h0000_1000);
    bus_write(6'h01, 32'hFFFF_FFFF);
    idle(3);
    bus_read(6'h03, d); check("R3 enabled later appears", d, 13);
    bus_read(6'h05, d); check("R7 nvec ch12", d, vexp(12));
    ack_port();
    idle(3);
    bus_read(6'h00, d); check("R8 cleared ch12", d, 0);
  endtask

  task automatic tc_fast();
    logic [31:0] d;
    bus_write(6'h02, 32'h0000_0400);
    pulse(32'h0000_8400);
    idle(3);
    check("R4 fiq_o high", {31'd0, fiq_o}, 1);
    bus_read(6'h04, d); check("R4 fidx", d, 11);
    bus_read(6'h03, d); check("R4 nidx", d, 16);
    check("R10 port shows normal only", vport_addr, vexp(15));
    bus_read(6'h06, d); check("R7 fvec", d, vexp(10));
    idle(3);
    check("R8 fiq_o low", {31'd0, fiq_o}, 0);
    bus_read(6'h00, d); check("R8 fast read clear", d, 32'h0000_8000);
    ack_port();
    idle(3);
    bus_read(6'h00, d); check("R9 ack clears ch15", d, 0);
    bus_write(6'h02, 32'h0);
  endtask

  task automatic tc_port();
    logic [31:0] d;
    pulse(32'h0000_0044);
    idle(3);
    check("R9 valid", {31'd0, vport_valid}, 1);
    check("R9 addr ch2", vport_addr, vexp(2));
    idle(5);
    check("R9 addr stable", vport_addr, vexp(2));
    ack_port();
    check("R9 valid drops", {31'd0, vport_valid}, 0);
    idle(3);
    check("R9 next addr", vport_addr, vexp(6));
    bus_read(6'h00, d); check("R9 ack cleared ch2", d, 32'h0000_0040);
    ack_port();
    idle(3);
    check("R9 port empty", {31'd0, vport_valid}, 0);
    bus_read(6'h00, d); check("R9 all cleared", d, 0);
  endtask

  initial begin
    rst = 1'b1; irq_src = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; vport_ack = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(1);
    tc_reset();
    tc_latch();
    tc_w1c();
    for (int c = 0; c < NCH; c++) bus_write(6'h20 + 6'(c), vexp(c));
    tc_prio();
    tc_masked_read();
    tc_fast();
    tc_port();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule